// File: doc/BRIEF.md
# Three-Port Register File with Memory Data Register

This block is the register storage of a small two-phase microprogrammed datapath. It holds eight 16-bit registers and serves three ports in the same clock cycle. Port A is write-only and takes the ALU result. Port B is read-only: the register it selects drives the address bus, which is also the ALU's A operand. Port C is wired permanently to register 0, which acts as the memory data register.

Every memory transfer goes through register 0. The direction of port C depends on the phase and the read strobe. In an execute-phase read, port C loads the memory data bus into register 0. In every other cycle, register 0 drives the data bus, where it serves as memory write data and as the ALU's B operand. In a fetch-phase read the instruction register takes the memory data, so register 0 is left alone.

Register 7 is the program counter and also has a dedicated output for the sequencer. Port B can select the same register that port A writes, so an address can be used and then incremented or decremented in a single cycle. Port A writes on every clock edge. The ALU and the memory are outside the block.

Top module: `tri_port_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, all eight registers are cleared. Afterwards `addr_bus` reads 0 for every `rd_sel`, and `data_bus_out` and `pc_out` are 0.
- R2: At every rising edge not in reset, `wr_data` is written into the register numbered by `wr_sel`, except in the case covered by R7.
- R3: `addr_bus` shows, with no clock delay, the value that register `rd_sel` holds before the next edge. When `rd_sel` equals `wr_sel`, the old value is shown in that cycle and the new value from the next cycle on.
- R4: When `exec_phase`=1 and `mem_rd`=1, `mdr_capture` is 1 and `mem_din` is loaded into register 0 at the edge. Otherwise `mdr_capture` is 0.
- R5: With `exec_phase`=0 and `mem_rd`=1 (a fetch read), register 0 does not take `mem_din`. It changes only if port A targets it.
- R6: `data_bus_out` always equals the current content of register 0. `data_oe` is 1 in every cycle except those with `mdr_capture`=1.
- R7: If an execute-phase read coincides with `wr_sel`=0, `conflict` is 1 and register 0 takes `mem_din` rather than `wr_data`. `conflict` is 0 in all other cycles.
- R8: An execute-phase read with `wr_sel`≠0 updates register 0 from `mem_din` and register `wr_sel` from `wr_data` at the same edge.
- R9: `pc_out` always equals the content of register 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| exec_phase | input | 1 | 1 = execute phase, 0 = fetch phase |
| mem_rd | input | 1 | Memory read strobe for the current cycle |
| wr_sel | input | 3 | Port A destination register number |
| wr_data | input | 16 | Port A write data (ALU result) |
| rd_sel | input | 3 | Port B source register number |
| mem_din | input | 16 | Memory data bus, read direction |
| addr_bus | output | 16 | Port B value: memory address and ALU A operand |
| data_bus_out | output | 16 | Register 0 value: write data and ALU B operand |
| data_oe | output | 1 | Register 0 is driving the data bus |
| mdr_capture | output | 1 | Port C is loading register 0 from the data bus this cycle |
| conflict | output | 1 | Port A and port C both target register 0 this cycle |
| pc_out | output | 16 | Register 7 (program counter) |

## Verification
Port B exposes any register in the same cycle it is selected, so a corrupted register shows on `addr_bus` the first time it is read. Register 0 and register 7 are visible every cycle on `data_bus_out` and `pc_out`, so a wrong capture, a lost port A write or a wrong conflict resolution shows one clock after the faulty edge. The bench selects port B registers in a sweep and at random, so a bad write to any other register shows within a few cycles.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_EXEC  = 1'b1
  } phase_e;

  // Port C turns inward only for a read issued in the execute phase.
  function automatic logic portc_inward(phase_e ph, logic rd);
    return (ph == PH_EXEC) && rd;
  endfunction

  // Port A and port C collide when both aim at the data register.
  function automatic logic ports_collide(logic inward, logic dst_is_mdr);
    return inward && dst_is_mdr;
  endfunction

endpackage

// File: rtl/rf_portc_ctl.sv
module rf_portc_ctl
  import regfile_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          exec_phase,
  input  logic          mem_rd,
  input  logic [AW-1:0] wr_sel,
  output logic          capture,
  output logic          drive_en,
  output logic          collide
);

  phase_e ph;

  always_comb begin
    ph       = phase_e'(exec_phase);
    capture  = portc_inward(ph, mem_rd);
    drive_en = !capture;
    collide  = ports_collide(capture, wr_sel == '0);
  end

endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int W  = 16,
  parameter int N  = 8,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [AW-1:0] wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic [W-1:0]  mem_din,
  input  logic [AW-1:0] rd_sel,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  mdr_q,
  output logic [W-1:0]  pc_q
);

  localparam int PC_IDX = N - 1;

  logic [W-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    localparam logic [AW-1:0] IDX = AW'(i);
    logic hit;
    logic take_mem;
    assign take_mem = (i == 0) && capture;
    assign hit      = (wr_sel == IDX) && !take_mem;

    always_ff @(posedge clk) begin
      if (rst)           regs[i] <= '0;
      else if (take_mem) regs[i] <= mem_din;
      else if (hit)      regs[i] <= wr_data;
    end
  end

  assign rd_data = regs[rd_sel];
  assign mdr_q   = regs[0];
  assign pc_q    = regs[PC_IDX];

  // R9: a port A write to the program counter lands on pc_q one cycle later
  p_pc_write_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_sel == AW'(PC_IDX)) |=> (pc_q == $past(wr_data)));

  // R2: the program counter holds when port A aims elsewhere
  p_pc_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_sel != AW'(PC_IDX)) |=> $stable(pc_q));

endmodule

// File: rtl/tri_port_regfile.sv
module tri_port_regfile #(
  parameter int WIDTH = 16,
  parameter int NREGS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     exec_phase,
  input  logic                     mem_rd,
  input  logic [$clog2(NREGS)-1:0] wr_sel,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic [$clog2(NREGS)-1:0] rd_sel,
  input  logic [WIDTH-1:0]         mem_din,
  output logic [WIDTH-1:0]         addr_bus,
  output logic [WIDTH-1:0]         data_bus_out,
  output logic                     data_oe,
  output logic                     mdr_capture,
  output logic                     conflict,
  output logic [WIDTH-1:0]         pc_out
);

  localparam int AW = $clog2(NREGS);

  logic             cap_w;
  logic             drive_w;
  logic             collide_w;
  logic [WIDTH-1:0] mdr_w;
  logic [WIDTH-1:0] pc_w;
  logic [WIDTH-1:0] rd_w;

  rf_portc_ctl #(.AW(AW)) u_ctl (
    .exec_phase (exec_phase),
    .mem_rd     (mem_rd),
    .wr_sel     (wr_sel),
    .capture    (cap_w),
    .drive_en   (drive_w),
    .collide    (collide_w)
  );

  rf_bank #(.W(WIDTH), .N(NREGS), .AW(AW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .capture (cap_w),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .mem_din (mem_din),
    .rd_sel  (rd_sel),
    .rd_data (rd_w),
    .mdr_q   (mdr_w),
    .pc_q    (pc_w)
  );

  assign addr_bus     = rd_w;
  assign data_bus_out = mdr_w;
  assign data_oe      = drive_w;
  assign mdr_capture  = cap_w;
  assign conflict     = collide_w;
  assign pc_out       = pc_w;

  // R4: an execute-phase read loads the data register from the bus
  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (exec_phase && mem_rd) |=> (data_bus_out == $past(mem_din)));

  // R7: a collision can only arise while port C is capturing
  p_conflict_cap_r7: assert property (@(posedge clk) disable iff (rst)
    conflict |-> (mdr_capture && !data_oe));

  // R5: without a capture or a port A hit, the data register holds
  p_mdr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!mdr_capture && wr_sel != '0) |=> $stable(data_bus_out));

  // R2: port A alone writes the data register when port C is idle
  p_mdr_write_r2: assert property (@(posedge clk) disable iff (rst)
    (!mdr_capture && wr_sel == '0) |=> (data_bus_out == $past(wr_data)));

endmodule

// File: tb/tri_port_regfile_test.sv
`timescale 1ns/100ps
module tri_port_regfile_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exec_phase = 1'b0;
  logic        mem_rd = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [15:0] wr_data = 16'h0;
  logic [2:0]  rd_sel = 3'd0;
  logic [15:0] mem_din = 16'h0;
  logic [15:0] addr_bus, data_bus_out, pc_out;
  logic        data_oe, mdr_capture, conflict;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int model [8];

  always #2.5 clk = ~clk;

  tri_port_regfile uut (
    .clk(clk), .rst(rst), .exec_phase(exec_phase), .mem_rd(mem_rd),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .mem_din(mem_din),
    .addr_bus(addr_bus), .data_bus_out(data_bus_out), .data_oe(data_oe),
    .mdr_capture(mdr_capture), .conflict(conflict), .pc_out(pc_out)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at the falling edge, compare outputs, then advance the model.
  task automatic step(string tag, bit r, bit ex, bit rd, int ws, int wd, int rs, int md);
    bit reading;
    @(negedge clk);
    rst = r; exec_phase = ex; mem_rd = rd;
    wr_sel = 3'(ws); wr_data = 16'(wd); rd_sel = 3'(rs); mem_din = 16'(md);
    #1;
    reading = ex && rd;
    check(tag,  int'(addr_bus), model[rs]);
    check("R6", int'(data_bus_out), model[0]);
    check("R6", int'(data_oe), int'(!reading));
    check("R4", int'(mdr_capture), int'(reading));
    check("R7", int'(conflict), int'(reading && ws == 0));
    check("R9", int'(pc_out), model[7]);
    @(posedge clk);
    if (r) begin
      foreach (model[k]) model[k] = 0;
    end else begin
      if (reading) model[0] = md & 16'hFFFF;
      if (!(reading && ws == 0)) model[ws] = wd & 16'hFFFF;
    end
  endtask

  initial begin
    foreach (model[k]) model[k] = 0;
    step("R1", 1, 0, 0, 1, 16'h1234, 0, 0);
    step("R1", 1, 0, 0, 2, 16'h4321, 0, 0);
    // R1: every register reads zero after reset (writes of zero keep it so)
    for (int i = 0; i < 8; i++) step("R1", 0, 0, 0, 1, 0, i, 0);

    // R2: fill each register through port A
    for (int i = 0; i < 8; i++) step("R2", 0, 0, 0, i, 16'h1111 * i + 5, 0, 0);
    // R3: read back every register on port B
    for (int i = 0; i < 8; i++) step("R3", 0, 0, 0, 1, model[1], i, 0);

    // R3: post-increment then post-decrement of R3 read on the same port
    step("R3", 0, 0, 0, 3, model[3] + 1, 3, 0);
    step("R3", 0, 0, 0, 3, model[3] + 1, 3, 0);
    step("R3", 0, 0, 0, 3, model[3] - 1, 3, 0);
    step("R3", 0, 0, 0, 3, model[3], 3, 0);

    // R4 / R8: execute read into R0 while incrementing the PC
    step("R8", 0, 1, 1, 7, model[7] + 1, 7, 16'hBEEF);
    step("R8", 0, 0, 0, 2, model[2], 7, 0);
    // R5: fetch read leaves R0 untouched
    step("R5", 0, 0, 1, 7, model[7] + 1, 0, 16'h5A5A);
    step("R5", 0, 0, 1, 7, model[7] + 1, 0, 16'hA5A5);
    step("R5", 0, 0, 0, 4, model[4], 0, 0);
    // R7: conflict, memory data wins over port A
    step("R7", 0, 1, 1, 0, 16'h0BAD, 0, 16'hC0DE);
    step("R7", 0, 0, 0, 5, model[5], 0, 0);
    // R6: port A writes R0 when no capture, execute phase without read
    step("R6", 0, 1, 0, 0, 16'h7777, 0, 16'h1111);
    step("R6", 0, 0, 1, 0, 16'h8888, 0, 16'h2222);
    step("R6", 0, 0, 0, 6, model[6], 0, 0);

    // R8: mixed random traffic
    for (int i = 0; i < 400; i++)
      step("R8", 0, 1'($urandom), 1'($urandom), int'($urandom % 8),
           int'($urandom & 16'hFFFF), int'($urandom % 8), int'($urandom & 16'hFFFF));

    // R1: reset in mid-run clears everything
    step("R1", 1, 1, 1, 0, 16'hFFFF, 0, 16'hFFFF);
    for (int i = 0; i < 8; i++) step("R1", 0, 0, 0, 1, 0, i, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule